// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A sub-second divider counts a clock-enable strobe that marks each period of the 32.768 kHz reference. When the count of strobes reaches one second, it issues a one-cycle tick. Each tick advances the seconds, and each carry ripples through the minutes, the hours and the calendar. Month lengths are corrected, and the leap-year rule holds for every year from 00 to 99.

A parallel register port loads and reads the counters. One address selects a register. A write strobe loads that register, and the read data shows the selected register at all times without a clock. The hours register can be written in either of two formats: 24-hour, or 12-hour with an AM/PM flag. Counting then continues in the format that was written. A halt flag in the seconds register freezes all counting. Any write to the seconds register restarts the sub-second phase, so the first tick after a time load comes one full second after that write.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count in BCD from 00 to 59. On a tick, 59 returns to 00 and carries into the next field.
- R2: When hours bit 6 is 0 (24-hour format), bits 5:0 hold BCD 00 to 23, with bit 5 as the twenties digit. A carry at 23 returns to 00 and advances the date.
- R3: When hours bit 6 is 1 (12-hour format), bits 4:0 hold BCD 01 to 12 and bit 5 is PM. A carry at 11 goes to 12 and inverts PM. A carry at 12 goes to 01 and leaves PM unchanged. The date advances only when 11 PM becomes 12 AM.
- R4: The date (address 4) counts from 01 to the last day of the month, then returns to 01 and advances the month (address 5). The last day is 30 for months 04, 06, 09 and 11, and 31 for every other month except 02.
- R5: February ends on 29 when the BCD year (address 6) is divisible by 4, and on 28 otherwise. Year 00 is a leap year.
- R6: At midnight the day of week (address 3) advances and wraps from 7 to 1. The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R7: While seconds bit 7 (halt) is 1, no register advances, however many strobes arrive. Writes to the registers are still accepted.
- R8: The seconds advance on the clock edge of the DIV_COUNT-th strobe after the sub-second phase was cleared. This edge is the falling edge of the 1 Hz square wave.
- R9: A write to the seconds register clears the sub-second divider.
- R10: After reset the registers read as follows: seconds 0x80 (halted at 00), minutes 0x00, hours 0x00 (24-hour format), day 0x01, date 0x01, month 0x01, year 0x00.
- R11: Bits that a register does not use read back as 0. The used bits are: seconds 7:0, minutes 6:0, hours 6:0, day 2:0, date 5:0, month 4:0, year 7:0. Address 7 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle strobe for each reference oscillator period |
| wr_en | input | 1 | Write strobe for the selected register |
| addr | input | 3 | Register select for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register, combinational |

## Verification
The bench goes after the roll-overs that a single ripple carry must get right:

- **Midnight on 31 December 99.** Here every field wraps at once. A broken chain leaves one field stale.
- **The 12-hour edges.** A design that inverts PM on 12→01 shows 01 AM after noon. A design that advances the date at 12 noon moves the calendar twice a day.
- **Month ends.** These cover 30-day months, 31-day months, February in leap years (00, 16, 24) and February in a common year (23). A wrong length table either skips a day or shows a 29, 30 or 31 that does not exist.

Directed tests cover three further behaviours:

- **Divider clear.** A seconds write in the middle of a second must restart the phase. A design that ignores it ticks early.
- **Halt.** A design that lets strobes through while halted moves the seconds.
- **Unused bits.** Writing all ones to each register exposes any unused bits that are stored.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg: register addresses and BCD helper functions shared by
// the time-of-day and calendar counters. All values are packed BCD bytes.
package rtc_pkg;

    localparam logic [2:0] ADDR_SEC   = 3'd0;
    localparam logic [2:0] ADDR_MIN   = 3'd1;
    localparam logic [2:0] ADDR_HOUR  = 3'd2;
    localparam logic [2:0] ADDR_DOW   = 3'd3;
    localparam logic [2:0] ADDR_DATE  = 3'd4;
    localparam logic [2:0] ADDR_MONTH = 3'd5;
    localparam logic [2:0] ADDR_YEAR  = 3'd6;

    // Next BCD value: wraps from top to bottom, otherwise adds one decimally.
    function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] bottom);
        if (v == top)
            return bottom;
        else if (v[3:0] >= 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    // Leap test on a two-digit BCD year: divisible by four.
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0)
            return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
        else
            return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    endfunction

    // Last date of a BCD month, taking the year into account for February.
    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
// Module rtc_divider: counts oscillator strobes and emits a one-cycle tick
// on the strobe that completes DIV_COUNT of them (the falling edge of the
// 1 Hz square wave, whose high half is the upper half of the count).
// Assumes DIV_COUNT >= 2. A clear input restarts the phase at zero and
// suppresses the tick in that cycle; halt freezes the count.
module rtc_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic halt,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt;

    // Tick on the strobe that closes the second, unless cleared or halted.
    assign tick = osc_en && !halt && !clr && (cnt == LAST);

    // Sub-second phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (osc_en && !halt)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // R9: a seconds write leaves the phase at zero.
    a_r9_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R7: while halted and not cleared, the phase does not move.
    a_r7_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rtc_time_cnt.sv
// Module rtc_time_cnt: seconds (with halt flag), minutes and hours in BCD.
// Hours count in whichever format bit 6 holds (1 = 12-hour with PM in bit 5).
// Emits day_carry in the cycle the hours wrap into a new day. A register
// write takes precedence over the increment of that register.
module rtc_time_cnt
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       halt,
    output logic       day_carry
);
    logic wr_sec, wr_min, wr_hour;
    logic inc_min, inc_hour, hour_last;
    logic [7:0] sec_n, min_n, hour_n, h12_step, h24_step;
    logic mode12, pm;

    assign wr_sec  = wr_en && (addr == ADDR_SEC);
    assign wr_min  = wr_en && (addr == ADDR_MIN);
    assign wr_hour = wr_en && (addr == ADDR_HOUR);
    assign halt    = sec_q[7];
    assign mode12  = hour_q[6];
    assign pm      = hour_q[5];

    // Carry chain and next values for the three time fields.
    always_comb begin
        sec_n     = {1'b0, 7'(bcd_next({1'b0, sec_q[6:0]}, 8'h59, 8'h00))};
        min_n     = bcd_next(min_q, 8'h59, 8'h00);
        inc_min   = tick && (sec_q[6:0] == 7'h59);
        inc_hour  = inc_min && (min_q == 8'h59);
        h12_step  = bcd_next({3'b000, hour_q[4:0]}, 8'hFF, 8'h00);
        h24_step  = bcd_next({2'b00, hour_q[5:0]}, 8'h23, 8'h00);
        if (mode12) begin
            hour_last = (hour_q[4:0] == 5'h11) && pm;
            if (hour_q[4:0] == 5'h12)
                hour_n = {2'b01, pm, 5'h01};
            else if (hour_q[4:0] == 5'h11)
                hour_n = {2'b01, !pm, 5'h12};
            else
                hour_n = {2'b01, pm, h12_step[4:0]};
        end else begin
            hour_last = (hour_q[5:0] == 6'h23);
            hour_n    = {2'b00, h24_step[5:0]};
        end
        day_carry = inc_hour && hour_last;
    end

    // Seconds register with halt flag; reset halted at 00.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= 8'h80;
        else if (wr_sec)
            sec_q <= wr_data;
        else if (tick)
            sec_q <= {sec_q[7], sec_n[6:0]};
    end

    // Minutes register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            min_q <= 8'h00;
        else if (wr_min)
            min_q <= {1'b0, wr_data[6:0]};
        else if (inc_min)
            min_q <= min_n;
    end

    // Hours register in either format.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hour_q <= 8'h00;
        else if (wr_hour)
            hour_q <= {1'b0, wr_data[6:0]};
        else if (inc_hour)
            hour_q <= hour_n;
    end

    // R1: seconds at 59 return to 00 on a tick.
    a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_sec && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

    // R7: while halted, the time fields hold unless written.
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

    // R3: the step from 11 to 12 in 12-hour format inverts PM.
    a_r3_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_hour && !wr_hour && mode12 && hour_q[4:0] == 5'h11)
        |=> (hour_q[5] != $past(hour_q[5])));

    // R2: 24-hour format at 23 wraps to 00.
    a_r2_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_hour && !wr_hour && !mode12 && hour_q[5:0] == 6'h23)
        |=> (hour_q == 8'h00));

endmodule

// File: rtl/rtc_date_cnt.sv
// Module rtc_date_cnt: day of week, date, month and year in BCD. Advances on
// day_carry from the time counter; month length follows rtc_pkg::month_last.
// A register write takes precedence over the increment of that register.
module rtc_date_cnt
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_carry,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] dow_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    logic wr_dow, wr_date, wr_month, wr_year;
    logic [7:0] last_day;
    logic inc_month, inc_year;

    assign wr_dow   = wr_en && (addr == ADDR_DOW);
    assign wr_date  = wr_en && (addr == ADDR_DATE);
    assign wr_month = wr_en && (addr == ADDR_MONTH);
    assign wr_year  = wr_en && (addr == ADDR_YEAR);

    // Month-end detection and calendar carries.
    always_comb begin
        last_day  = month_last(month_q, year_q);
        inc_month = day_carry && (date_q == last_day);
        inc_year  = inc_month && (month_q == 8'h12);
    end

    // Day of week, 1 to 7.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dow_q <= 8'h01;
        else if (wr_dow)
            dow_q <= {5'b0, wr_data[2:0]};
        else if (day_carry)
            dow_q <= bcd_next(dow_q, 8'h07, 8'h01);
    end

    // Date of the month.
    always_ff @(posedge clk) begin
        if (!rst_n)
            date_q <= 8'h01;
        else if (wr_date)
            date_q <= {2'b0, wr_data[5:0]};
        else if (day_carry)
            date_q <= bcd_next(date_q, last_day, 8'h01);
    end

    // Month.
    always_ff @(posedge clk) begin
        if (!rst_n)
            month_q <= 8'h01;
        else if (wr_month)
            month_q <= {3'b0, wr_data[4:0]};
        else if (inc_month)
            month_q <= bcd_next(month_q, 8'h12, 8'h01);
    end

    // Two-digit year.
    always_ff @(posedge clk) begin
        if (!rst_n)
            year_q <= 8'h00;
        else if (wr_year)
            year_q <= wr_data;
        else if (inc_year)
            year_q <= bcd_next(year_q, 8'h99, 8'h00);
    end

    // R4: a carry on the last day returns the date to 01.
    a_r4_date_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_month && !wr_date) |=> (date_q == 8'h01));

    // R6: day of week wraps from 7 to 1 at midnight.
    a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && !wr_dow && dow_q == 8'h07) |=> (dow_q == 8'h01));

    // R6: without a day carry or write, the calendar holds.
    a_r6_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_carry && !wr_en) |=> ($stable(date_q) && $stable(month_q) && $stable(year_q)));

endmodule

// File: rtl/bcd_rtc_core.sv
// Module bcd_rtc_core: top of the BCD clock/calendar. Ties the sub-second
// divider to the time and date counters and decodes the register port.
// Assumes osc_en is a one-cycle strobe per reference period, synchronous to clk.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_COUNT = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    logic tick, halt, day_carry, clr_phase;
    logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;

    assign clr_phase = wr_en && (addr == ADDR_SEC);

    rtc_divider #(.DIV_COUNT(DIV_COUNT)) div_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(halt),
        .clr(clr_phase), .tick(tick)
    );

    rtc_time_cnt time_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
        .halt(halt), .day_carry(day_carry)
    );

    rtc_date_cnt date_i (
        .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .dow_q(dow_q), .date_q(date_q),
        .month_q(month_q), .year_q(year_q)
    );

    // Register read multiplexer; address 7 reads zero.
    always_comb begin
        case (addr)
            ADDR_SEC:   rd_data = sec_q;
            ADDR_MIN:   rd_data = min_q;
            ADDR_HOUR:  rd_data = hour_q;
            ADDR_DOW:   rd_data = dow_q;
            ADDR_DATE:  rd_data = date_q;
            ADDR_MONTH: rd_data = month_q;
            ADDR_YEAR:  rd_data = year_q;
            default:    rd_data = 8'h00;
        endcase
    end

    // R11: address 7 always reads zero.
    a_r11_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd7) |-> (rd_data == 8'h00));

endmodule

// File: tb/bcd_rtc_core_tb_top.sv
// Bench for bcd_rtc_core: a table of one-second steps across roll-overs,
// then directed tests for reset, halt, divider phase and unused bits.
module bcd_rtc_core_tb_top;
    localparam int DIV = 4;
    localparam int NV  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_en = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_rtc_core #(.DIV_COUNT(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // Each entry: loaded {sec,min,hour,dow,date,month,year}, then expected after one second.
    localparam logic [111:0] VEC [NV] = '{
        112'h05000001010100_06000001010100, // R1 units step
        112'h09120802100305_10120802100305, // R1 tens step
        112'h59341203050621_00351203050621, // R1 minute carry
        112'h59590904070722_00001004070722, // R2 hour 09->10
        112'h59592307311299_00000001010100, // R6 full wrap, R2 23->00
        112'h59595102140830_00007202140830, // R3 11AM->12PM
        112'h59597202140830_00006102140830, // R3 12PM->01PM
        112'h59597103150830_00005204160830, // R3 11PM->12AM, date steps
        112'h59592305280224_00000006290224, // R5 leap 24
        112'h59592306290224_00000007010324, // R5 Feb 29 end
        112'h59592301280223_00000002010323, // R5 common year
        112'h59592302300410_00000003010510, // R4 April
        112'h59592303310110_00000004010210, // R4 January
        112'h59592304280200_00000005290200, // R5 year 00
        112'h59592305300915_00000006011015, // R4 September
        112'h59595206010101_00004106010101, // R3 12AM->01AM
        112'h59592301280216_00000002290216, // R5 leap 16
        112'h59592302300640_00000003010740, // R4 June
        112'h59592303300740_00000004310740, // R4 July has 31
        112'h59594907111111_00005007111111  // R3 09->10 in 12-hour
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_en = 1'b1;
        end
        @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_all(output logic [55:0] v);
        logic [7:0] b;
        for (int k = 0; k < 7; k++) begin
            rd(3'(k), b);
            v[55 - 8*k -: 8] = b;
        end
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int k = 1; k < 7; k++) wr(3'(k), v[55 - 8*k -: 8]);
        wr(3'd0, v[55:48]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [55:0] got;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state.
        rd_all(got);
        chk("R10 reset state", 64'(got), 64'h80000001010100);

        // R7 halted after reset: strobes do not advance.
        strobes(3 * DIV);
        rd(3'd0, b);
        chk("R7 halted seconds", 64'(b), 64'h80);
        wr(3'd1, 8'h42);
        rd(3'd1, b);
        chk("R7 write while halted", 64'(b), 64'h42);

        // Vector table: load, run one second, compare all seven registers.
        for (int v = 0; v < NV; v++) begin
            load_all(VEC[v][111:56]);
            strobes(DIV);
            rd_all(got);
            chk($sformatf("vector %0d R1/R2/R3/R4/R5/R6", v), 64'(got), 64'(VEC[v][55:0]));
        end

        // R8 second boundary: DIV-1 strobes hold, the DIV-th advances.
        wr(3'd0, 8'h20);
        strobes(DIV - 1);
        rd(3'd0, b);
        chk("R8 before boundary", 64'(b), 64'h20);
        strobes(1);
        rd(3'd0, b);
        chk("R8 on boundary", 64'(b), 64'h21);
        strobes(2 * DIV);
        rd(3'd0, b);
        chk("R8 two more seconds", 64'(b), 64'h23);

        // R9 seconds write mid-second restarts the phase.
        strobes(DIV - 1);
        wr(3'd0, 8'h10);
        strobes(DIV - 1);
        rd(3'd0, b);
        chk("R9 phase cleared", 64'(b), 64'h10);
        strobes(1);
        rd(3'd0, b);
        chk("R9 full second after clear", 64'(b), 64'h11);

        // R7 setting halt stops counting.
        wr(3'd0, 8'h85);
        strobes(3 * DIV);
        rd(3'd0, b);
        chk("R7 halt set", 64'(b), 64'h85);

        // R11 unused bits and spare address.
        wr(3'd1, 8'hFF); rd(3'd1, b); chk("R11 minutes mask", 64'(b), 64'h7F);
        wr(3'd2, 8'hFF); rd(3'd2, b); chk("R11 hours mask", 64'(b), 64'h7F);
        wr(3'd3, 8'hFF); rd(3'd3, b); chk("R11 day mask", 64'(b), 64'h07);
        wr(3'd4, 8'hFF); rd(3'd4, b); chk("R11 date mask", 64'(b), 64'h3F);
        wr(3'd5, 8'hFF); rd(3'd5, b); chk("R11 month mask", 64'(b), 64'h1F);
        wr(3'd7, 8'hFF); rd(3'd7, b); chk("R11 spare address", 64'(b), 64'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule